// File: doc/BRIEF.md
# Hint-Driven Instruction Prefetch Engine

This block turns front-end prefetch hints into line requests toward a second-level cache and parks the returned lines in a small streaming buffer. Fetch logic can look them up there. Each hint names a starting line and picks one of two modes. A burst covers a fixed number of lines. A stream walks successive lines until a taken branch, a flush or a newer hint ends it.

Every candidate line is first shown on a probe port, where the instruction cache and TLB answer in the same cycle. A line that is already cached is skipped and never requested. Requests leave through a valid/ready handshake, and responses return in request order. The number of requests in flight is capped. Buffer entries plus requests in flight never exceed the buffer depth, so every response has a slot waiting for it.

A fetch lookup that hits returns the line combinationally and releases the entry at the next edge. A flush empties the buffer, stops generation and marks every request still in flight, so that its response is dropped when it arrives.

Top module: `ipf_engine`

## Requirements
- R1: While reset is held and just after it, `req_valid_o` and `probe_valid_o` are low and every fetch lookup misses.
- R2: A hint with `hint_stream_i`=0 (burst) produces exactly BURST_LINES (default 2) candidate lines: the hint line, then the following line(s), in increasing order.
- R3: A hint with `hint_stream_i`=1 (stream) produces candidates at successive line addresses. Once `taken_br_i` is sampled high, no further request is issued until a new hint arrives.
- R4: A candidate for which `probe_hit_i` is high (answered in the same cycle as `probe_valid_o`) is dropped, never requested, and generation moves to the next line. `req_valid_o` is never high while `probe_hit_i` is high.
- R5: A request is taken only in a cycle where `req_valid_o` and `req_ready_i` are both high. While `req_ready_i` is low, the same line is held on `req_line_o`.
- R6: At most MAX_OUT (default 4) requests are in flight. At that count, `req_valid_o` stays low.
- R7: Buffered lines plus requests in flight never exceed ENTRIES (default 8). When that limit is reached, issue stalls, and it resumes only after a lookup frees an entry.
- R8: Responses are matched to requests in issue order. A buffered line returns the data delivered for that line.
- R9: A fetch lookup that matches a buffered line raises `fetch_hit_o` and shows the data in the same cycle. The entry is freed, so a repeated lookup of the same line misses.
- R10: A hint that arrives while another hint is still generating aborts the old one. Only the new hint's lines are requested after it.
- R11: `flush_i` empties the buffer and cancels generation. Responses for requests issued before the flush are discarded, and later requests and responses still pair up correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hint_valid_i | input | 1 | Hint strobe |
| hint_line_i | input | LAW (27) | Starting line address of the hint |
| hint_stream_i | input | 1 | 0 = burst, 1 = stream |
| taken_br_i | input | 1 | Taken branch seen; stops generation |
| flush_i | input | 1 | Empty buffer, cancel generation, drop in-flight responses |
| probe_valid_o | output | 1 | Candidate line presented for a presence check |
| probe_line_o | output | LAW | Candidate line address |
| probe_hit_i | input | 1 | Candidate already present in cache and TLB (same cycle) |
| req_valid_o | output | 1 | Line request valid |
| req_ready_i | input | 1 | Second-level cache accepts the request |
| req_line_o | output | LAW | Requested line address |
| rsp_valid_i | input | 1 | Response for the oldest request in flight |
| rsp_data_i | input | LINE_W (256) | Response line data |
| fetch_valid_i | input | 1 | Fetch lookup strobe |
| fetch_line_i | input | LAW | Lookup line address |
| fetch_hit_o | output | 1 | Lookup matched a buffered line |
| fetch_data_o | output | LINE_W | Data of the matched line |

## Verification
The bound checker watches, on every cycle, the properties that hold at all times: the in-flight cap, the combined buffer-plus-flight limit, the absence of requests on probe hits, the one-entry release after a lookup hit, and the quiet cycle after a taken branch or a flush. The scenarios cover what depends on history. These are the exact line sequences of bursts and streams under several probe-hit masks, the stall and refill around a full buffer, a stream aborted by a newer hint, and stale responses dropped after a flush while later responses still land in the right entries.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  typedef enum logic {
    MODE_BURST  = 1'b0,
    MODE_STREAM = 1'b1
  } ipf_mode_e;
endpackage

// File: rtl/ipf_hint_gen.sv
module ipf_hint_gen
  import ipf_pkg::*;
#(
  parameter int LAW         = 27,
  parameter int BURST_LINES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hint_valid_i,
  input  logic [LAW-1:0] hint_line_i,
  input  ipf_mode_e      hint_mode_i,
  input  logic           taken_i,
  input  logic           flush_i,
  input  logic           probe_hit_i,
  input  logic           room_i,
  input  logic           req_ready_i,
  output logic           cand_valid_o,
  output logic [LAW-1:0] cand_line_o,
  output logic           req_valid_o,
  output logic           issue_o
);
  localparam int CW = $clog2(BURST_LINES + 1);

  logic           act_q;
  logic [LAW-1:0] line_q;
  ipf_mode_e      mode_q;
  logic [CW-1:0]  left_q;
  logic           adv;

  always_comb begin
    cand_valid_o = act_q & ~flush_i & ~hint_valid_i & ~taken_i;
    req_valid_o  = cand_valid_o & ~probe_hit_i & room_i;
    issue_o      = req_valid_o & req_ready_i;
    // a cached line is skipped without needing room
    adv          = issue_o | (cand_valid_o & probe_hit_i);
    cand_line_o  = line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      line_q <= '0;
      mode_q <= MODE_BURST;
      left_q <= '0;
    end else if (flush_i) begin
      act_q <= 1'b0;
    end else if (hint_valid_i) begin
      act_q  <= 1'b1;
      line_q <= hint_line_i;
      mode_q <= hint_mode_i;
      left_q <= CW'(BURST_LINES);
    end else if (taken_i) begin
      act_q <= 1'b0;
    end else if (adv) begin
      line_q <= line_q + 1'b1;
      if (mode_q == MODE_BURST) begin
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipf_req_track.sv
module ipf_req_track #(
  parameter int LAW   = 27,
  parameter int DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [LAW-1:0]             push_line_i,
  input  logic                       pop_i,
  input  logic                       flush_i,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic [LAW-1:0]             head_line_o,
  output logic                       head_stale_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [LAW-1:0]   line_q [DEPTH];
  logic [DEPTH-1:0] stale_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stale_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
    end else begin
      if (push_i) begin
        stale_q[wr_q] <= 1'b0;
        wr_q          <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
      // everything in flight at a flush becomes stale
      if (flush_i) stale_q <= '1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) line_q[wr_q] <= push_line_i;
  end

  assign count_o      = cnt_q;
  assign head_line_o  = line_q[rd_q];
  assign head_stale_o = stale_q[rd_q];
endmodule

// File: rtl/ipf_line_buf.sv
module ipf_line_buf #(
  parameter int LAW     = 27,
  parameter int LINE_W  = 256,
  parameter int ENTRIES = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         wr_i,
  input  logic [LAW-1:0]               wr_line_i,
  input  logic [LINE_W-1:0]            wr_data_i,
  input  logic                         rd_valid_i,
  input  logic [LAW-1:0]               rd_line_i,
  output logic                         rd_hit_o,
  output logic [LINE_W-1:0]            rd_data_o,
  output logic [$clog2(ENTRIES+1)-1:0] count_o
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] valid_q;
  logic [LAW-1:0]     tag_q  [ENTRIES];
  logic [LINE_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IW-1:0]      hit_idx, free_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == rd_line_i);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])    hit_idx  = IW'(i);
      if (!valid_q[i]) free_idx = IW'(i);
    end
    rd_hit_o  = rd_valid_i && (|match);
    rd_data_o = data_q[hit_idx];
    count_o   = CW'($countones(valid_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (rd_hit_o) valid_q[hit_idx]  <= 1'b0;
      if (wr_i)     valid_q[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      tag_q[free_idx]  <= wr_line_i;
      data_q[free_idx] <= wr_data_i;
    end
  end
endmodule

// File: rtl/ipf_engine.sv
module ipf_engine
  import ipf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int ENTRIES     = 8,
  parameter int MAX_OUT     = 4,
  parameter int BURST_LINES = 2,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int LAW        = ADDR_W - OFF_W,
  localparam int LINE_W     = 8 * LINE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hint_valid_i,
  input  logic [LAW-1:0]    hint_line_i,
  input  logic              hint_stream_i,
  input  logic              taken_br_i,
  input  logic              flush_i,
  output logic              probe_valid_o,
  output logic [LAW-1:0]    probe_line_o,
  input  logic              probe_hit_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [LAW-1:0]    req_line_o,
  input  logic              rsp_valid_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  input  logic              fetch_valid_i,
  input  logic [LAW-1:0]    fetch_line_i,
  output logic              fetch_hit_o,
  output logic [LINE_W-1:0] fetch_data_o
);
  localparam int OCW = $clog2(MAX_OUT + 1);
  localparam int BCW = $clog2(ENTRIES + 1);
  localparam int SW  = ((OCW > BCW) ? OCW : BCW) + 1;

  logic           cand_valid, issue, room;
  logic [LAW-1:0] cand_line;
  logic [OCW-1:0] out_cnt;
  logic [BCW-1:0] buf_cnt;
  logic [LAW-1:0] head_line;
  logic           head_stale, buf_wr;
  logic [SW-1:0]  occ;

  // slots are reserved at issue so a response always finds a free entry
  always_comb begin
    occ  = SW'(buf_cnt) + SW'(out_cnt);
    room = (occ < SW'(ENTRIES)) && (out_cnt < OCW'(MAX_OUT));
  end

  ipf_hint_gen #(
    .LAW(LAW), .BURST_LINES(BURST_LINES)
  ) u_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hint_valid_i (hint_valid_i),
    .hint_line_i  (hint_line_i),
    .hint_mode_i  (ipf_mode_e'(hint_stream_i)),
    .taken_i      (taken_br_i),
    .flush_i      (flush_i),
    .probe_hit_i  (probe_hit_i),
    .room_i       (room),
    .req_ready_i  (req_ready_i),
    .cand_valid_o (cand_valid),
    .cand_line_o  (cand_line),
    .req_valid_o  (req_valid_o),
    .issue_o      (issue)
  );

  ipf_req_track #(
    .LAW(LAW), .DEPTH(MAX_OUT)
  ) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (issue),
    .push_line_i  (cand_line),
    .pop_i        (rsp_valid_i),
    .flush_i      (flush_i),
    .count_o      (out_cnt),
    .head_line_o  (head_line),
    .head_stale_o (head_stale)
  );

  assign buf_wr = rsp_valid_i && !head_stale && !flush_i;

  ipf_line_buf #(
    .LAW(LAW), .LINE_W(LINE_W), .ENTRIES(ENTRIES)
  ) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .wr_i       (buf_wr),
    .wr_line_i  (head_line),
    .wr_data_i  (rsp_data_i),
    .rd_valid_i (fetch_valid_i),
    .rd_line_i  (fetch_line_i),
    .rd_hit_o   (fetch_hit_o),
    .rd_data_o  (fetch_data_o),
    .count_o    (buf_cnt)
  );

  assign probe_valid_o = cand_valid;
  assign probe_line_o  = cand_line;
  assign req_line_o    = cand_line;
endmodule

// File: rtl/ipf_engine_chk.sv
module ipf_engine_chk #(
  parameter int ENTRIES = 8,
  parameter int MAX_OUT = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         flush_i,
  input logic                         hint_valid_i,
  input logic                         taken_br_i,
  input logic                         probe_hit_i,
  input logic                         req_valid_o,
  input logic                         fetch_hit_o,
  input logic [$clog2(MAX_OUT+1)-1:0] out_cnt,
  input logic [$clog2(ENTRIES+1)-1:0] buf_cnt,
  input logic                         buf_wr
);
  a_r4_no_req_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !probe_hit_i);

  a_r6_inflight_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(out_cnt) <= MAX_OUT);

  a_r7_slot_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(out_cnt) + int'(buf_cnt) <= ENTRIES);

  a_r9_hit_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_hit_o && !flush_i) |=>
      (int'(buf_cnt) + 1 == int'($past(buf_cnt)) + int'($past(buf_wr))));

  a_r3_taken_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_br_i && !hint_valid_i) |=> !req_valid_o);

  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (buf_cnt == '0) && !req_valid_o);
endmodule

bind ipf_engine ipf_engine_chk #(
  .ENTRIES(ENTRIES), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .hint_valid_i (hint_valid_i),
  .taken_br_i   (taken_br_i),
  .probe_hit_i  (probe_hit_i),
  .req_valid_o  (req_valid_o),
  .fetch_hit_o  (fetch_hit_o),
  .out_cnt      (out_cnt),
  .buf_cnt      (buf_cnt),
  .buf_wr       (buf_wr)
);

// File: tb/ipf_engine_test.sv
`timescale 1ns/1ps
module ipf_engine_test;
  localparam int LAW    = 27;
  localparam int LINE_W = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hint_valid = 1'b0;
  logic [LAW-1:0]    hint_line = '0;
  logic              hint_stream = 1'b0;
  logic              taken = 1'b0;
  logic              flush = 1'b0;
  logic              probe_valid;
  logic [LAW-1:0]    probe_line;
  logic              probe_hit;
  logic              req_valid;
  logic              req_ready = 1'b1;
  logic [LAW-1:0]    req_line;
  logic              rsp_valid = 1'b0;
  logic [LINE_W-1:0] rsp_data = '0;
  logic              fetch_valid = 1'b0;
  logic [LAW-1:0]    fetch_line = '0;
  logic              fetch_hit;
  logic [LINE_W-1:0] fetch_data;

  logic [15:0]    cached = '0;
  bit             rsp_en = 1'b1;
  logic [LAW-1:0] log_q [0:255];
  int             log_cnt = 0;
  int             rsp_idx = 0;
  int             checks = 0;
  int             fails = 0;
  bit             done = 1'b0;

  always #2.5 clk = ~clk;

  // cache/TLB model: a line is present when its mask bit is set
  assign probe_hit = probe_valid && cached[probe_line[3:0]];

  ipf_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hint_valid_i(hint_valid), .hint_line_i(hint_line), .hint_stream_i(hint_stream),
    .taken_br_i(taken), .flush_i(flush),
    .probe_valid_o(probe_valid), .probe_line_o(probe_line), .probe_hit_i(probe_hit),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_line_o(req_line),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .fetch_valid_i(fetch_valid), .fetch_line_i(fetch_line),
    .fetch_hit_o(fetch_hit), .fetch_data_o(fetch_data)
  );

  function automatic logic [LINE_W-1:0] line_data(input logic [LAW-1:0] l);
    return {8{32'(l) ^ 32'h5A5A_0000}};
  endfunction

  // request log, sampled mid-cycle
  initial forever begin
    @(negedge clk);
    if (rst_n && req_valid && req_ready) begin
      log_q[log_cnt] = req_line;
      log_cnt++;
    end
  end

  // second-level cache model: in-order replies
  initial forever begin
    @(posedge clk);
    #1;
    if (rsp_en && rsp_idx < log_cnt) begin
      rsp_valid = 1'b1;
      rsp_data  = line_data(log_q[rsp_idx]);
      rsp_idx++;
    end else begin
      rsp_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hint(input logic [LAW-1:0] l, input bit strm);
    hint_valid = 1'b1; hint_line = l; hint_stream = strm;
    cyc(1);
    hint_valid = 1'b0;
  endtask

  task automatic lookup(input logic [LAW-1:0] l, input bit exp_hit, input string tag);
    fetch_valid = 1'b1; fetch_line = l;
    #1;
    chk(fetch_hit == exp_hit, tag, 64'(fetch_hit), 64'(exp_hit));
    if (exp_hit && fetch_hit)
      chk(fetch_data == line_data(l), tag, fetch_data[63:0], line_data(l)[63:0]);
    cyc(1);
    fetch_valid = 1'b0;
  endtask

  task automatic pulse_taken();
    taken = 1'b1; cyc(1); taken = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1; cyc(1); flush = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int b;
    int n;
    logic [LAW-1:0] exp_l [0:7];
    logic [15:0] masks [0:2];
    masks[0] = 16'h5555; masks[1] = 16'h00F0; masks[2] = 16'h8001;

    // R1: reset state
    cyc(3);
    chk(req_valid == 1'b0, "R1 req_valid in reset", 64'(req_valid), 0);
    chk(probe_valid == 1'b0, "R1 probe_valid in reset", 64'(probe_valid), 0);
    rst_n = 1'b1;
    cyc(1);
    chk(req_valid == 1'b0, "R1 req_valid after reset", 64'(req_valid), 0);
    lookup(27'h40, 1'b0, "R1 empty buffer lookup");

    // R2 burst, R8/R9 lookups
    b = log_cnt;
    hint(27'h100, 1'b0);
    cyc(10);
    chk(log_cnt - b == 2, "R2 burst request count", 64'(log_cnt - b), 2);
    chk(log_q[b] == 27'h100, "R2 burst first line", 64'(log_q[b]), 64'h100);
    chk(log_q[b+1] == 27'h101, "R2 burst second line", 64'(log_q[b+1]), 64'h101);
    lookup(27'h100, 1'b1, "R9 lookup hit");
    lookup(27'h100, 1'b0, "R9 entry freed after hit");
    lookup(27'h101, 1'b1, "R8 second line data");

    // R4: probe filter sweep over a burst
    for (int m = 0; m < 4; m++) begin
      cached = 16'(m);
      b = log_cnt;
      hint(27'h200, 1'b0);
      cyc(10);
      n = 0;
      for (int k = 0; k < 2; k++) if (!cached[k]) begin exp_l[n] = 27'h200 + 27'(k); n++; end
      chk(log_cnt - b == n, "R4 burst filtered count", 64'(log_cnt - b), 64'(n));
      for (int k = 0; k < n; k++)
        chk(log_q[b+k] == exp_l[k], "R4 burst filtered line", 64'(log_q[b+k]), 64'(exp_l[k]));
      for (int k = 0; k < 2; k++)
        lookup(27'h200 + 27'(k), !cached[k], "R4 cached line not buffered");
      cached = '0;
    end

    // R6 in-flight cap, R7 full stall, R3 stream order and stop
    rsp_en = 1'b0;
    b = log_cnt;
    hint(27'h400, 1'b1);
    cyc(20);
    chk(log_cnt - b == 4, "R6 in-flight cap", 64'(log_cnt - b), 4);
    chk(req_valid == 1'b0, "R6 request held low at cap", 64'(req_valid), 0);
    rsp_en = 1'b1;
    cyc(30);
    chk(log_cnt - b == 8, "R7 stall at buffer depth", 64'(log_cnt - b), 8);
    chk(req_valid == 1'b0, "R7 request low when full", 64'(req_valid), 0);
    for (int k = 0; k < 8; k++)
      chk(log_q[b+k] == 27'h400 + 27'(k), "R3 stream sequential", 64'(log_q[b+k]), 64'(27'h400 + 27'(k)));
    lookup(27'h400, 1'b1, "R9 hit in full buffer");
    cyc(10);
    chk(log_cnt - b == 9, "R7 refill after free", 64'(log_cnt - b), 9);
    chk(log_q[b+8] == 27'h408, "R3 stream continues", 64'(log_q[b+8]), 64'h408);
    pulse_taken();
    lookup(27'h401, 1'b1, "R8 stream data");
    cyc(20);
    chk(log_cnt - b == 9, "R3 taken stops stream", 64'(log_cnt - b), 9);
    for (int k = 2; k <= 8; k++)
      lookup(27'h400 + 27'(k), 1'b1, "R8 stream data drain");

    // R4: stream under probe masks
    for (int p = 0; p < 3; p++) begin
      cached = masks[p];
      b = log_cnt;
      hint(27'h600, 1'b1);
      cyc(60);
      n = 0;
      for (int l = 27'h600; n < 8; l++) if (!cached[l[3:0]]) begin exp_l[n] = 27'(l); n++; end
      chk(log_cnt - b == 8, "R4 stream filtered count", 64'(log_cnt - b), 8);
      for (int k = 0; k < 8; k++)
        chk(log_q[b+k] == exp_l[k], "R4 stream filtered line", 64'(log_q[b+k]), 64'(exp_l[k]));
      pulse_taken();
      pulse_flush();
      cached = '0;
      cyc(20);
    end

    // R5 hold while not ready, R10 abort by newer hint
    rsp_en = 1'b0;
    req_ready = 1'b0;
    b = log_cnt;
    hint(27'h800, 1'b1);
    cyc(3);
    chk(req_valid == 1'b1, "R5 request pending", 64'(req_valid), 1);
    chk(req_line == 27'h800, "R5 line held without ready", 64'(req_line), 64'h800);
    chk(log_cnt == b, "R5 nothing taken without ready", 64'(log_cnt - b), 0);
    hint(27'h900, 1'b0);
    req_ready = 1'b1;
    cyc(10);
    chk(log_cnt - b == 2, "R10 only new hint requested", 64'(log_cnt - b), 2);
    chk(log_q[b] == 27'h900, "R10 new first line", 64'(log_q[b]), 64'h900);
    chk(log_q[b+1] == 27'h901, "R10 new second line", 64'(log_q[b+1]), 64'h901);
    rsp_en = 1'b1;
    cyc(10);
    lookup(27'h900, 1'b1, "R10 new line buffered");
    lookup(27'h901, 1'b1, "R10 new line buffered");
    lookup(27'h800, 1'b0, "R10 old stream not buffered");

    // R11 flush
    hint(27'hA00, 1'b0);
    cyc(10);
    rsp_en = 1'b0;
    b = log_cnt;
    hint(27'hB00, 1'b0);
    cyc(10);
    chk(log_cnt - b == 2, "R11 requests in flight before flush", 64'(log_cnt - b), 2);
    pulse_flush();
    chk(req_valid == 1'b0, "R11 no request after flush", 64'(req_valid), 0);
    rsp_en = 1'b1;
    cyc(10);
    lookup(27'hA00, 1'b0, "R11 buffered line flushed");
    lookup(27'hA01, 1'b0, "R11 buffered line flushed");
    lookup(27'hB00, 1'b0, "R11 stale response dropped");
    lookup(27'hB01, 1'b0, "R11 stale response dropped");
    hint(27'hC00, 1'b0);
    cyc(10);
    lookup(27'hC00, 1'b1, "R11 pairing after flush");
    lookup(27'hC01, 1'b1, "R11 pairing after flush");
    b = log_cnt;
    hint(27'hD00, 1'b1);
    cyc(3);
    pulse_flush();
    n = log_cnt;
    cyc(20);
    chk(log_cnt == n, "R11 flush cancels stream", 64'(log_cnt - b), 64'(n - b));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule